// File: doc/BRIEF.md
# Deferred-Commit Power Bus Write Engine

This block is the byte-level half of a power-management bus slave. A separate bit-level serial interface finds START and repeated START, STOP and whole received bytes, and it passes each one to the engine as a single-cycle strobe. For every byte, the engine returns an acknowledge decision one cycle later. It matches its own 7-bit write address. It then captures a command code and that command's data bytes and can check an optional CRC-8 packet error code (PEC) at the end of the segment.

The engine does not execute a complete segment straight away. It holds the segment pending until the STOP that closes the whole bus transaction. In that way, one transaction can carry a segment for each of several devices, joined by repeated STARTs, and every device acts on the same STOP. When the commit happens, the engine emits a single-cycle execute strobe that carries the code and data towards the register file. Faults are kept in a sticky three-bit status vector:
- an unknown command,
- a bad PEC,
- a write refused under write protection.

A zero-length clear command, committed at STOP, wipes that vector. After reset the engine is idle and has nothing pending, so the device runs on its defaults until the bus addresses it.

Top module: `pmbg_engine`

## Requirements
- R1: After reset, `ackStb`, `execStb` and `statusOut` are all zero.
- R2: The engine ACKs a byte that follows a START or repeated START only when bits [7:1] equal `DEV_ADDR` and bit 0 (read/write) is 0. Any other address byte, and every further byte up to the next START, is answered with NACK. Each `byteValid` produces exactly one `ackStb` pulse, in the next cycle.
- R3: The known commands take a fixed number of data bytes: 0x01 takes 1, 0x02 takes 1, 0x21 takes 2 and 0x03 takes 0. The engine ACKs the code and the data bytes. When the segment is complete, a STOP causes one single-cycle `execStb` in the cycle after the STOP. That pulse carries `execCode` and `execData`, with data byte i at bits [8i+7:8i] and the bytes that were not sent reading as zero.
- R4: No execution happens before STOP. A repeated START to another address does not discard a completed segment of this device, and that segment executes at the final STOP.
- R5: A STOP that arrives before all data bytes of the command have been received leaves nothing to execute.
- R6: A byte that follows a complete segment is treated as PEC. It is checked against a CRC-8 with polynomial 0x07, initial value 0x00 and bits taken MSB first, computed over the address, the code and the data bytes. When it matches, the byte is ACKed and the segment still executes at STOP.
- R7: A PEC mismatch is NACKed, the pending segment is discarded, and `statusOut[1]` is set.
- R8: An unknown command code sets `statusOut[0]`. With `NACK_UNSUP=1` (the default) the code byte and all later bytes are NACKed. With 0 they are all ACKed and nothing executes.
- R9: While `wpIn` is high, a known command that has data bytes is NACKed at its code byte and `statusOut[2]` is set. The zero-length clear command 0x03 is still accepted.
- R10: Status bits are sticky. They return to zero only in the cycle in which command 0x03 executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startDet | input | 1 | START or repeated START seen (one cycle) |
| stopDet | input | 1 | STOP seen (one cycle) |
| byteValid | input | 1 | A received byte is present on `byteIn` (one cycle) |
| byteIn | input | 8 | Received byte |
| wpIn | input | 1 | Write-protect level |
| ackStb | output | 1 | Acknowledge decision valid (one cycle) |
| ackOk | output | 1 | 1 = ACK, 0 = NACK, valid with `ackStb` |
| execStb | output | 1 | Commit strobe for the pending command |
| execCode | output | 8 | Committed command code |
| execData | output | 8*MAX_DATA | Committed data bytes, byte 0 lowest |
| statusOut | output | 3 | Sticky faults: [0] unknown code, [1] PEC error, [2] write refused |

## Verification
Several properties are checked on every cycle:
- every acknowledge pulse follows a received byte;
- every execute pulse follows a STOP and lasts one cycle;
- each fault bit rises only together with the acknowledge decision that caused it;
- status falls only together with a committed clear command.

Other behaviour can only be shown by the bench scenarios, which compare the execute payloads and acknowledge sequences with a reference model:
- whether the right segment survives a group transaction;
- whether a short segment is dropped;
- whether a computed PEC is accepted.

// File: rtl/pmbg_pkg.sv
package pmbg_pkg;

  localparam logic [7:0] CMD_OPER  = 8'h01;
  localparam logic [7:0] CMD_ONOFF = 8'h02;
  localparam logic [7:0] CMD_CLEAR = 8'h03;
  localparam logic [7:0] CMD_VOUT  = 8'h21;

  typedef struct packed {
    logic       known;
    logic [3:0] len;
  } cmdInfo_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_DATA, S_PEC, S_SINK
  } state_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic crcClr;
    logic crcAdd;
    logic codeLd;
    logic dataLd;
    logic pendSet;
    logic pendDrop;
    logic execTry;
    logic ackFire;
    logic ackOk;
    logic setUnsup;
    logic setPec;
    logic setWp;
  } strobe_t;

  function automatic cmdInfo_t lookupCmd(input logic [7:0] c);
    cmdInfo_t r;
    r = '0;
    case (c)
      CMD_OPER, CMD_ONOFF: begin r.known = 1'b1; r.len = 4'd1; end
      CMD_VOUT:            begin r.known = 1'b1; r.len = 4'd2; end
      CMD_CLEAR:           begin r.known = 1'b1; r.len = 4'd0; end
      default:             r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] crcStep(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] r;
    r = crc ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

endpackage

// File: rtl/pmbg_ctrl.sv
module pmbg_ctrl
  import pmbg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h2C,
  parameter bit         NACK_UNSUP = 1'b1,
  parameter int         CW         = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startDet,
  input  logic          stopDet,
  input  logic          byteValid,
  input  logic [7:0]    byteIn,
  input  logic          wpIn,
  input  logic [7:0]    crcCur,
  input  logic [CW-1:0] cnt,
  input  logic [7:0]    codeCur,
  output strobe_t       stb
);

  state_t   st, nxt;
  cmdInfo_t info;
  logic [3:0] curLen;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    stb    = '0;
    nxt    = st;
    info   = lookupCmd(byteIn);
    curLen = lookupCmd(codeCur).len;
    if (stopDet) begin
      stb.execTry = 1'b1;
      nxt = S_IDLE;
    end else if (startDet) begin
      stb.crcClr = 1'b1;
      nxt = S_ADDR;
    end else if (byteValid) begin
      stb.ackFire = 1'b1;
      case (st)
        S_ADDR: begin
          if (byteIn[7:1] == DEV_ADDR && !byteIn[0]) begin
            stb.ackOk = 1'b1; stb.crcAdd = 1'b1; stb.pendDrop = 1'b1;
            nxt = S_CMD;
          end else nxt = S_IDLE;
        end
        S_CMD: begin
          if (!info.known) begin
            stb.setUnsup = 1'b1;
            if (NACK_UNSUP) nxt = S_IDLE;
            else begin stb.ackOk = 1'b1; nxt = S_SINK; end
          end else if (wpIn && info.len != 4'd0) begin
            stb.setWp = 1'b1;
            nxt = S_IDLE;
          end else begin
            stb.ackOk = 1'b1; stb.crcAdd = 1'b1; stb.codeLd = 1'b1;
            if (info.len == 4'd0) begin stb.pendSet = 1'b1; nxt = S_PEC; end
            else nxt = S_DATA;
          end
        end
        S_DATA: begin
          stb.ackOk = 1'b1; stb.crcAdd = 1'b1; stb.dataLd = 1'b1;
          if (int'(cnt) + 1 == int'(curLen)) begin stb.pendSet = 1'b1; nxt = S_PEC; end
        end
        S_PEC: begin
          if (byteIn == crcCur) stb.ackOk = 1'b1;
          else begin stb.pendDrop = 1'b1; stb.setPec = 1'b1; end
          nxt = S_IDLE;
        end
        S_SINK:  stb.ackOk = 1'b1;
        default: nxt = S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pmbg_dpath.sv
module pmbg_dpath
  import pmbg_pkg::*;
#(
  parameter int MAX_DATA = 2,
  parameter int CW       = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [7:0]              byteIn,
  output logic [7:0]              crcCur,
  output logic [CW-1:0]           cnt,
  output logic [7:0]              codeCur,
  output logic                    ackStb,
  output logic                    ackOk,
  output logic                    execStb,
  output logic [7:0]              execCode,
  output logic [8*MAX_DATA-1:0]   execData,
  output logic [2:0]              statusOut
);

  logic [7:0] dataBuf [MAX_DATA];
  logic [8*MAX_DATA-1:0] dataFlat;
  logic pend;
  logic commit;

  assign commit = stb.execTry && pend;

  for (genvar i = 0; i < MAX_DATA; i++) begin : g_flat
    assign dataFlat[8*i +: 8] = dataBuf[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_DATA; i++) dataBuf[i] <= '0;
    end else if (stb.codeLd) begin
      for (int i = 0; i < MAX_DATA; i++) dataBuf[i] <= '0;
    end else if (stb.dataLd) begin
      for (int i = 0; i < MAX_DATA; i++)
        if (cnt == CW'(i)) dataBuf[i] <= byteIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcCur    <= '0;
      cnt       <= '0;
      codeCur   <= '0;
      pend      <= 1'b0;
      ackStb    <= 1'b0;
      ackOk     <= 1'b0;
      execStb   <= 1'b0;
      execCode  <= '0;
      execData  <= '0;
      statusOut <= '0;
    end else begin
      ackStb  <= stb.ackFire;
      ackOk   <= stb.ackFire && stb.ackOk;
      execStb <= commit;
      if (stb.crcClr)      crcCur <= '0;
      else if (stb.crcAdd) crcCur <= crcStep(crcCur, byteIn);
      if (stb.codeLd) begin
        codeCur <= byteIn;
        cnt     <= '0;
      end else if (stb.dataLd) cnt <= cnt + 1'b1;
      if (stb.pendDrop)     pend <= 1'b0;
      else if (stb.pendSet) pend <= 1'b1;
      else if (commit)      pend <= 1'b0;
      if (commit) begin
        execCode <= codeCur;
        execData <= dataFlat;
      end
      if (commit && codeCur == CMD_CLEAR) statusOut <= '0;
      else statusOut <= statusOut | {stb.setWp, stb.setPec, stb.setUnsup};
    end
  end

endmodule

// File: rtl/pmbg_engine.sv
module pmbg_engine
  import pmbg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h2C,
  parameter int         MAX_DATA   = 2,
  parameter bit         NACK_UNSUP = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startDet,
  input  logic                  stopDet,
  input  logic                  byteValid,
  input  logic [7:0]            byteIn,
  input  logic                  wpIn,
  output logic                  ackStb,
  output logic                  ackOk,
  output logic                  execStb,
  output logic [7:0]            execCode,
  output logic [8*MAX_DATA-1:0] execData,
  output logic [2:0]            statusOut
);

  localparam int CW = $clog2(MAX_DATA + 1);

  strobe_t       stb;
  logic [7:0]    crcCur;
  logic [CW-1:0] cnt;
  logic [7:0]    codeCur;

  pmbg_ctrl #(.DEV_ADDR(DEV_ADDR), .NACK_UNSUP(NACK_UNSUP), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .byteValid(byteValid), .byteIn(byteIn), .wpIn(wpIn),
    .crcCur(crcCur), .cnt(cnt), .codeCur(codeCur), .stb(stb)
  );

  pmbg_dpath #(.MAX_DATA(MAX_DATA), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIn(byteIn),
    .crcCur(crcCur), .cnt(cnt), .codeCur(codeCur),
    .ackStb(ackStb), .ackOk(ackOk), .execStb(execStb),
    .execCode(execCode), .execData(execData), .statusOut(statusOut)
  );

endmodule

// File: rtl/pmbg_chk.sv
module pmbg_chk #(
  parameter bit NACK_UNSUP = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       stopDet,
  input logic       byteValid,
  input logic       wpIn,
  input logic       ackStb,
  input logic       ackOk,
  input logic       execStb,
  input logic [7:0] execCode,
  input logic [2:0] statusOut
);

  AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |-> $past(byteValid)); // R2

  AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    execStb |=> !execStb); // R3

  AST_EXEC_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    execStb |-> $past(stopDet)); // R4

  AST_PEC_FAULT_NACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[1]) |-> (ackStb && !ackOk)); // R7

  AST_UNSUP_REPLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[0]) |-> (ackStb && (ackOk == !NACK_UNSUP))); // R8

  AST_WP_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[2]) |-> (ackStb && !ackOk && $past(wpIn))); // R9

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusOut) & ~statusOut) != 3'b000) |-> (execStb && execCode == 8'h03)); // R10

endmodule

bind pmbg_engine pmbg_chk #(.NACK_UNSUP(NACK_UNSUP)) u_chk (
  .clk(clk), .rstN(rstN), .stopDet(stopDet), .byteValid(byteValid),
  .wpIn(wpIn), .ackStb(ackStb), .ackOk(ackOk), .execStb(execStb),
  .execCode(execCode), .statusOut(statusOut)
);

// File: tb/sim_pmbg_engine.sv
module sim_pmbg_engine;

  localparam logic [7:0] MY_W = 8'h58;  // 7'h2C, write

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startDet = 1'b0, stopDet = 1'b0, byteValid = 1'b0, wpIn = 1'b0;
  logic [7:0] byteIn = '0;
  logic ackStb, ackOk, execStb;
  logic [7:0] execCode;
  logic [15:0] execData;
  logic [2:0] statusOut;

  always #5 clk = ~clk;

  pmbg_engine u0 (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .byteValid(byteValid), .byteIn(byteIn), .wpIn(wpIn),
    .ackStb(ackStb), .ackOk(ackOk), .execStb(execStb),
    .execCode(execCode), .execData(execData), .statusOut(statusOut)
  );

  typedef struct { logic ok; string req; } ackExp_t;
  typedef struct { logic [7:0] code; logic [15:0] data; string req; } execExp_t;
  ackExp_t  ackQ[$];
  execExp_t execQ[$];
  int total = 0;
  int bad = 0;

  task automatic note(input bit pass, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!pass) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    ackExp_t  ea;
    execExp_t ee;
    if (rstN) begin
      if (ackStb) begin
        if (ackQ.size() == 0) note(1'b0, "R2", "unexpected ack", 32'(ackOk), 0);
        else begin
          ea = ackQ.pop_front();
          note(ackOk == ea.ok, ea.req, "ack", 32'(ackOk), 32'(ea.ok));
        end
      end
      if (execStb) begin
        if (execQ.size() == 0) note(1'b0, "R4", "unexpected exec", 32'(execCode), 0);
        else begin
          ee = execQ.pop_front();
          note(execCode == ee.code && execData == ee.data, ee.req, "exec",
               {execCode, 8'h00, execData}, {ee.code, 8'h00, ee.data});
        end
      end
    end
  end

  function automatic logic [7:0] refCrc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic pulseStart();
    @(negedge clk) startDet = 1'b1;
    @(negedge clk) startDet = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk) stopDet = 1'b1;
    @(negedge clk) stopDet = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic ok, input string req);
    ackExp_t e;
    e.ok = ok; e.req = req;
    ackQ.push_back(e);
    @(negedge clk) begin byteValid = 1'b1; byteIn = b; end
    @(negedge clk) byteValid = 1'b0;
  endtask

  task automatic expectExec(input logic [7:0] code, input logic [15:0] data, input string req);
    execExp_t e;
    e.code = code; e.data = data; e.req = req;
    execQ.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    note(1'b0, "R1", "watchdog expired", 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] p;
    repeat (3) @(negedge clk);
    note(ackStb == 1'b0, "R1", "reset ackStb", 32'(ackStb), 0);
    note(execStb == 1'b0, "R1", "reset execStb", 32'(execStb), 0);
    note(statusOut == 3'b000, "R1", "reset status", 32'(statusOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3: two-byte command
    pulseStart();
    sendByte(MY_W, 1'b1, "R2");
    sendByte(8'h21, 1'b1, "R3");
    sendByte(8'h34, 1'b1, "R3");
    sendByte(8'h12, 1'b1, "R3");
    expectExec(8'h21, 16'h1234, "R3");
    pulseStop();

    // R2: foreign address and read bit
    pulseStart();
    sendByte(8'h5A, 1'b0, "R2");
    sendByte(8'h01, 1'b0, "R2");
    pulseStart();
    sendByte(8'h59, 1'b0, "R2");
    pulseStop();

    // R4: group transaction, own segment first
    pulseStart();
    sendByte(MY_W, 1'b1, "R4");
    sendByte(8'h01, 1'b1, "R4");
    sendByte(8'h80, 1'b1, "R4");
    pulseStart();
    sendByte(8'h40, 1'b0, "R4");
    sendByte(8'h02, 1'b0, "R4");
    pulseStart();
    sendByte(8'h42, 1'b0, "R4");
    sendByte(8'h77, 1'b0, "R4");
    repeat (3) @(negedge clk);
    note(execQ.size() == 0, "R4", "no exec before stop", 0, 0);
    expectExec(8'h01, 16'h0080, "R4");
    pulseStop();

    // R5: stop before the second data byte
    pulseStart();
    sendByte(MY_W, 1'b1, "R5");
    sendByte(8'h21, 1'b1, "R5");
    sendByte(8'h55, 1'b1, "R5");
    pulseStop();

    // R6: good PEC
    p = refCrc(refCrc(refCrc(8'h00, MY_W), 8'h02), 8'h0F);
    pulseStart();
    sendByte(MY_W, 1'b1, "R6");
    sendByte(8'h02, 1'b1, "R6");
    sendByte(8'h0F, 1'b1, "R6");
    sendByte(p, 1'b1, "R6");
    expectExec(8'h02, 16'h000F, "R6");
    pulseStop();
    note(statusOut == 3'b000, "R6", "status after good pec", 32'(statusOut), 0);

    // R7: bad PEC
    p = refCrc(refCrc(refCrc(refCrc(8'h00, MY_W), 8'h21), 8'h34), 8'h12);
    pulseStart();
    sendByte(MY_W, 1'b1, "R7");
    sendByte(8'h21, 1'b1, "R7");
    sendByte(8'h34, 1'b1, "R7");
    sendByte(8'h12, 1'b1, "R7");
    sendByte(p ^ 8'h01, 1'b0, "R7");
    pulseStop();
    note(statusOut == 3'b010, "R7", "pec fault bit", 32'(statusOut), 32'(3'b010));

    // R8: unknown code
    pulseStart();
    sendByte(MY_W, 1'b1, "R8");
    sendByte(8'h99, 1'b0, "R8");
    sendByte(8'h12, 1'b0, "R8");
    pulseStop();
    note(statusOut == 3'b011, "R8", "unsupported bit", 32'(statusOut), 32'(3'b011));

    // R10: clear command
    pulseStart();
    sendByte(MY_W, 1'b1, "R10");
    sendByte(8'h03, 1'b1, "R10");
    expectExec(8'h03, 16'h0000, "R10");
    pulseStop();
    note(statusOut == 3'b000, "R10", "status cleared", 32'(statusOut), 0);

    // R9: write protect
    wpIn = 1'b1;
    pulseStart();
    sendByte(MY_W, 1'b1, "R9");
    sendByte(8'h02, 1'b0, "R9");
    sendByte(8'h01, 1'b0, "R9");
    pulseStop();
    note(statusOut == 3'b100, "R9", "wp bit", 32'(statusOut), 32'(3'b100));
    pulseStart();
    sendByte(MY_W, 1'b1, "R9");
    sendByte(8'h03, 1'b1, "R9");
    expectExec(8'h03, 16'h0000, "R9");
    pulseStop();
    note(statusOut == 3'b000, "R10", "clear under wp", 32'(statusOut), 0);
    wpIn = 1'b0;

    repeat (5) @(negedge clk);
    note(ackQ.size() == 0, "R2", "acks outstanding", ackQ.size(), 0);
    note(execQ.size() == 0, "R3", "execs outstanding", execQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule